// File: doc/BRIEF.md
# Alarm Match and Multi-Function Output Controller

This block sits beside the timekeeping registers of a real-time clock. Every time the BCD time fields advance it compares them against a set of alarm fields. Five repeat bits decide how many of those fields take part in the comparison. A successful comparison sets an alarm flag. An interrupt state machine owns that flag. It defers the flag while the register pointer rests on the flags address, and it drops the flag when the flags register is read.

The same block drives two open-drain outputs, modelled as active-high "pull low" signals. The multi-function pin has three modes:
- a programmable square wave, picked from a binary divider;
- an interrupt that follows the alarm flag;
- a static level taken from a control bit.

A second output carries the fastest divider stage as a 32768 Hz clock. That output runs only while it is enabled and the oscillator is not stopped.

The divider advances on `osc_half_tick`, a strobe that pulses twice per oscillator period. Bit k of the divider therefore toggles at 32768/2^k Hz.

The interrupt state machine has three states:
- `IRQ_QUIET`: no alarm is pending.
- `IRQ_HELD`: a match arrived while the pointer sat on the flags address.
- `IRQ_RAISED`: the flag is set.

Its transitions are:
- QUIET→RAISED: a match with the pointer elsewhere.
- QUIET→HELD: a match with the pointer on the flags address.
- HELD→RAISED: the pointer leaves the flags address.
- RAISED→QUIET: a flags read with no match in the same cycle.

Every other case holds the current state.

Top module: `alarm_out_ctl`

## Requirements
- R1: `rpt_bits` (bit 4 down to bit 0) selects which fields must be equal when `time_upd` is high:
  - 11111: none.
  - 11110: seconds.
  - 11100: seconds and minutes.
  - 11000: seconds, minutes and hour.
  - 10000: the day-of-month date as well.
  - 00000: the month as well.
  Fields outside the selection have no effect.
- R2: Any other `rpt_bits` code behaves as 11111, so every `time_upd` is a match.
- R3: A match is taken only in a cycle with `time_upd` high. `alarm_flag` rises after that clock edge; equal fields without `time_upd` set nothing.
- R4: A match while `reg_ptr` equals FLAG_ADDR (0x0F) leaves `alarm_flag` low, even if `flags_rd` is pulsed meanwhile. The flag rises one edge after `reg_ptr` holds another value.
- R5: `flags_rd` high with `alarm_flag` set clears the flag at the next edge. If a match occurs in the same cycle, the flag stays set.
- R6: With `alm_en`=1 and `sqw_en`=0, `mfp_pull_low` equals `alarm_flag`.
- R7: With `sqw_en`=1, the pin carries the square wave whatever `alm_en` is:
  - `rate_sel`=0 releases the pin.
  - `rate_sel`=1 pulls it low when divider bit 0 is 0.
  - `rate_sel`=n (2..15) pulls it low when divider bit n is 0.
- R8: With `alm_en`=0 and `sqw_en`=0, `mfp_pull_low` is the inverse of `out_level`.
- R9: `f32_pull_low` is high only when `f32_en`=1, `osc_stop`=0 and divider bit 0 is 0. The divider counts `osc_half_tick` pulses only while `osc_stop`=0.
- R10: After reset the state is QUIET and the divider is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_half_tick | input | 1 | Strobe, two per 32768 Hz oscillator period |
| time_upd | input | 1 | Time fields have just advanced |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 6 | Current hour, BCD |
| tm_date | input | 6 | Current day of month, BCD |
| tm_month | input | 5 | Current month, BCD |
| al_sec | input | 7 | Alarm seconds |
| al_min | input | 7 | Alarm minutes |
| al_hour | input | 6 | Alarm hour |
| al_date | input | 6 | Alarm date |
| al_month | input | 5 | Alarm month |
| rpt_bits | input | 5 | Repeat selection |
| alm_en | input | 1 | Alarm output enable |
| sqw_en | input | 1 | Square wave enable |
| rate_sel | input | 4 | Square wave rate code |
| out_level | input | 1 | Static pin level |
| f32_en | input | 1 | 32 kHz output enable |
| osc_stop | input | 1 | Oscillator stopped |
| flags_rd | input | 1 | Flags register read strobe |
| reg_ptr | input | 8 | Current register pointer |
| alarm_flag | output | 1 | Alarm flag |
| mfp_pull_low | output | 1 | Multi-function pin pulled low |
| f32_pull_low | output | 1 | 32 kHz pin pulled low |

## Verification
A new match and a flags read can land in the same cycle. The precedence rule says the fresh event wins, so the flag must survive that cycle. The bench forces the collision in a directed case with the flag already raised, and the random phase pulses both strobes independently. A bench model applies the rule and is compared against the flag after each edge. A second collision puts a match on the flags address and a read in the same cycle. The bench checks that the deferred flag neither rises nor gets lost.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
    localparam int SEC_W      = 7;
    localparam int MIN_W      = 7;
    localparam int HOUR_W     = 6;
    localparam int DATE_W     = 6;
    localparam int MON_W      = 5;
    localparam int FIELD_W    = 7;
    localparam int NUM_FIELDS = 5;
    localparam int RPT_W      = 5;
    localparam int RATE_W     = 4;

    typedef enum logic [2:0] {
        RPT_EVERY_SEC   = 3'd0,
        RPT_EVERY_MIN   = 3'd1,
        RPT_EVERY_HOUR  = 3'd2,
        RPT_EVERY_DAY   = 3'd3,
        RPT_EVERY_MONTH = 3'd4,
        RPT_EVERY_YEAR  = 3'd5
    } rpt_mode_e;

    typedef enum logic [1:0] {
        IRQ_QUIET  = 2'd0,
        IRQ_HELD   = 2'd1,
        IRQ_RAISED = 2'd2
    } irq_state_e;

    typedef enum logic [1:0] {
        PIN_STATIC = 2'd0,
        PIN_ALARM  = 2'd1,
        PIN_WAVE   = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/alm_rpt_decode.sv
`timescale 1ns/1ps
module alm_rpt_decode
    import alm_pkg::*;
(
    input  logic [RPT_W-1:0] rpt_bits,
    output rpt_mode_e        mode
);
    always_comb begin
        unique case (rpt_bits)
            5'b11111: mode = RPT_EVERY_SEC;
            5'b11110: mode = RPT_EVERY_MIN;
            5'b11100: mode = RPT_EVERY_HOUR;
            5'b11000: mode = RPT_EVERY_DAY;
            5'b10000: mode = RPT_EVERY_MONTH;
            5'b00000: mode = RPT_EVERY_YEAR;
            default:  mode = RPT_EVERY_SEC;  // unlisted codes fall back
        endcase
    end
endmodule

// File: rtl/alm_match.sv
`timescale 1ns/1ps
module alm_match
    import alm_pkg::*;
(
    input  rpt_mode_e                      mode,
    input  logic [NUM_FIELDS*FIELD_W-1:0]  now_vec,
    input  logic [NUM_FIELDS*FIELD_W-1:0]  alm_vec,
    output logic                           fields_ok
);
    logic [NUM_FIELDS-1:0] ok;

    // Field i (0 = seconds ... 4 = month) joins the compare when the mode scope exceeds i
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        logic needed;
        logic equal;
        assign needed = (int'(mode) > i);
        assign equal  = (now_vec[i*FIELD_W +: FIELD_W] == alm_vec[i*FIELD_W +: FIELD_W]);
        assign ok[i]  = !needed || equal;
    end

    assign fields_ok = &ok;
endmodule

// File: rtl/alm_irq_fsm.sv
`timescale 1ns/1ps
module alm_irq_fsm
    import alm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic at_flag,
    input  logic flags_rd,
    output logic flag_set
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (hit) begin
                    state_d = at_flag ? IRQ_HELD : IRQ_RAISED;
                end
            end
            IRQ_HELD: begin
                if (!at_flag) begin
                    state_d = IRQ_RAISED;
                end
            end
            IRQ_RAISED: begin
                // a fresh match outranks a simultaneous read
                if (flags_rd && !hit) begin
                    state_d = IRQ_QUIET;
                end
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        flag_set = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/sqw_divider.sv
`timescale 1ns/1ps
module sqw_divider
    import alm_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              stop,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              f32_en,
    output logic              wave_low,
    output logic              f32_low
);
    localparam int TAP_W = $clog2(DIV_W);

    logic [DIV_W-1:0] cnt_q;
    logic [TAP_W-1:0] tap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick && !stop) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // code 1 takes stage 0, code n >= 2 takes stage n
    always_comb begin
        tap = (rate_sel == RATE_W'(1)) ? '0 : TAP_W'(rate_sel);
    end

    assign wave_low = (rate_sel != '0) && !cnt_q[tap];
    assign f32_low  = f32_en && !stop && !cnt_q[0];
endmodule

// File: rtl/alarm_out_ctl.sv
`timescale 1ns/1ps
module alarm_out_ctl
    import alm_pkg::*;
#(
    parameter int          PTR_W     = 8,
    parameter logic [7:0]  FLAG_ADDR = 8'h0F,
    parameter int          DIV_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_half_tick,
    input  logic              time_upd,
    input  logic [SEC_W-1:0]  tm_sec,
    input  logic [MIN_W-1:0]  tm_min,
    input  logic [HOUR_W-1:0] tm_hour,
    input  logic [DATE_W-1:0] tm_date,
    input  logic [MON_W-1:0]  tm_month,
    input  logic [SEC_W-1:0]  al_sec,
    input  logic [MIN_W-1:0]  al_min,
    input  logic [HOUR_W-1:0] al_hour,
    input  logic [DATE_W-1:0] al_date,
    input  logic [MON_W-1:0]  al_month,
    input  logic [RPT_W-1:0]  rpt_bits,
    input  logic              alm_en,
    input  logic              sqw_en,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              out_level,
    input  logic              f32_en,
    input  logic              osc_stop,
    input  logic              flags_rd,
    input  logic [PTR_W-1:0]  reg_ptr,
    output logic              alarm_flag,
    output logic              mfp_pull_low,
    output logic              f32_pull_low
);
    localparam int VEC_W = NUM_FIELDS * FIELD_W;

    rpt_mode_e        mode;
    logic [VEC_W-1:0] now_vec;
    logic [VEC_W-1:0] alm_vec;
    logic             fields_ok;
    logic             hit;
    logic             at_flag;
    logic             wave_low;
    pin_mode_e        pin_mode;

    assign now_vec = {FIELD_W'(tm_month), FIELD_W'(tm_date), FIELD_W'(tm_hour),
                      FIELD_W'(tm_min), FIELD_W'(tm_sec)};
    assign alm_vec = {FIELD_W'(al_month), FIELD_W'(al_date), FIELD_W'(al_hour),
                      FIELD_W'(al_min), FIELD_W'(al_sec)};

    alm_rpt_decode u_dec (
        .rpt_bits (rpt_bits),
        .mode     (mode)
    );

    alm_match u_match (
        .mode      (mode),
        .now_vec   (now_vec),
        .alm_vec   (alm_vec),
        .fields_ok (fields_ok)
    );

    assign hit     = time_upd && fields_ok;
    assign at_flag = (reg_ptr == PTR_W'(FLAG_ADDR));

    alm_irq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .at_flag  (at_flag),
        .flags_rd (flags_rd),
        .flag_set (alarm_flag)
    );

    sqw_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_half_tick),
        .stop     (osc_stop),
        .rate_sel (rate_sel),
        .f32_en   (f32_en),
        .wave_low (wave_low),
        .f32_low  (f32_pull_low)
    );

    always_comb begin
        if (sqw_en) begin
            pin_mode = PIN_WAVE;
        end else if (alm_en) begin
            pin_mode = PIN_ALARM;
        end else begin
            pin_mode = PIN_STATIC;
        end
    end

    always_comb begin
        unique case (pin_mode)
            PIN_WAVE:   mfp_pull_low = wave_low;
            PIN_ALARM:  mfp_pull_low = alarm_flag;
            PIN_STATIC: mfp_pull_low = !out_level;
            default:    mfp_pull_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/alarm_out_ctl_sva.sv
`timescale 1ns/1ps
module alarm_out_ctl_sva #(
    parameter int PTR_W = 8,
    parameter logic [7:0] FLAG_ADDR = 8'h0F
) (
    input logic             clk,
    input logic             rst_n,
    input logic             time_upd,
    input logic             flags_rd,
    input logic [PTR_W-1:0] reg_ptr,
    input logic             alm_en,
    input logic             sqw_en,
    input logic [3:0]       rate_sel,
    input logic             out_level,
    input logic             f32_en,
    input logic             osc_stop,
    input logic             alarm_flag,
    input logic             mfp_pull_low,
    input logic             f32_pull_low
);
    AST_FLAG_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> ($past(reg_ptr) != PTR_W'(FLAG_ADDR))); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && flags_rd && !time_upd) |=> !alarm_flag); // R5

    AST_ALARM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (alm_en && !sqw_en) |-> (mfp_pull_low == alarm_flag)); // R6

    AST_WAVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (sqw_en && rate_sel == 4'd0) |-> !mfp_pull_low); // R7

    AST_STATIC_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_en && !sqw_en) |-> (mfp_pull_low != out_level)); // R8

    AST_F32_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!f32_en || osc_stop) |-> !f32_pull_low); // R9
endmodule

bind alarm_out_ctl alarm_out_ctl_sva #(.PTR_W(PTR_W), .FLAG_ADDR(FLAG_ADDR)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .time_upd     (time_upd),
    .flags_rd     (flags_rd),
    .reg_ptr      (reg_ptr),
    .alm_en       (alm_en),
    .sqw_en       (sqw_en),
    .rate_sel     (rate_sel),
    .out_level    (out_level),
    .f32_en       (f32_en),
    .osc_stop     (osc_stop),
    .alarm_flag   (alarm_flag),
    .mfp_pull_low (mfp_pull_low),
    .f32_pull_low (f32_pull_low)
);

// File: tb/alarm_out_ctl_tb_top.sv
`timescale 1ns/1ps
module alarm_out_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_half_tick = 1'b0;
    logic       time_upd = 1'b0;
    logic [6:0] tm_sec = '0, al_sec = '0;
    logic [6:0] tm_min = '0, al_min = '0;
    logic [5:0] tm_hour = '0, al_hour = '0;
    logic [5:0] tm_date = '0, al_date = '0;
    logic [4:0] tm_month = '0, al_month = '0;
    logic [4:0] rpt_bits = 5'b11111;
    logic       alm_en = 1'b0;
    logic       sqw_en = 1'b0;
    logic [3:0] rate_sel = '0;
    logic       out_level = 1'b1;
    logic       f32_en = 1'b1;
    logic       osc_stop = 1'b0;
    logic       flags_rd = 1'b0;
    logic [7:0] reg_ptr = '0;
    logic       alarm_flag, mfp_pull_low, f32_pull_low;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    int          m_state = 0;   // 0 quiet, 1 held, 2 raised
    logic [15:0] m_cnt = '0;

    always #4 clk = ~clk;

    alarm_out_ctl dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_match();
        bit s, m, h, d, mo;
        s  = (tm_sec == al_sec);
        m  = (tm_min == al_min);
        h  = (tm_hour == al_hour);
        d  = (tm_date == al_date);
        mo = (tm_month == al_month);
        case (rpt_bits)
            5'b11110: return s;
            5'b11100: return s && m;
            5'b11000: return s && m && h;
            5'b10000: return s && m && h && d;
            5'b00000: return s && m && h && d && mo;
            default:  return 1'b1;
        endcase
    endfunction

    function automatic bit exp_pin();
        int idx;
        idx = (rate_sel == 4'd1) ? 0 : int'(rate_sel);
        if (sqw_en) return (rate_sel != 4'd0) && !m_cnt[idx];
        if (alm_en) return m_state == 2;
        return !out_level;
    endfunction

    function automatic string pin_tag();
        if (sqw_en) return "R7";
        if (alm_en) return "R6";
        return "R8";
    endfunction

    // check model against outputs, then advance one edge
    task automatic step();
        bit hit, atf;
        #1;
        chk("R3 flag", alarm_flag, m_state == 2);
        chk({pin_tag(), " pin"}, mfp_pull_low, exp_pin());
        chk("R9 f32", f32_pull_low, f32_en && !osc_stop && !m_cnt[0]);
        hit = time_upd && exp_match();
        atf = (reg_ptr == 8'h0F);
        @(posedge clk);
        case (m_state)
            0: if (hit) m_state = atf ? 1 : 2;
            1: if (!atf) m_state = 2;
            default: if (flags_rd && !hit) m_state = 0;
        endcase
        if (osc_half_tick && !osc_stop) m_cnt = m_cnt + 16'd1;
        @(negedge clk);
    endtask

    task automatic time_eq();
        tm_sec = al_sec; tm_min = al_min; tm_hour = al_hour;
        tm_date = al_date; tm_month = al_month;
    endtask

    task automatic clear_flag();
        time_upd = 0; flags_rd = 1; reg_ptr = 8'h03; step();
        flags_rd = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0A1A);
        @(negedge clk);
        #1;
        chk("R10 flag", alarm_flag, 0);
        chk("R10 f32", f32_pull_low, 1);
        chk("R10 pin", mfp_pull_low, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 minute repeat: seconds only
        alm_en = 1;
        al_sec = 7'h30; al_min = 7'h12; tm_sec = 7'h30; tm_min = 7'h44;
        rpt_bits = 5'b11110; time_upd = 1; step(); time_upd = 0;
        chk("R1 minute match", alarm_flag, 1);
        chk("R6 pin", mfp_pull_low, 1);
        clear_flag();
        chk("R5 cleared", alarm_flag, 0);
        tm_sec = 7'h31; time_upd = 1; step(); time_upd = 0;
        chk("R1 seconds differ", alarm_flag, 0);

        // R1 year repeat: month participates
        al_sec = 7'h05; al_min = 7'h06; al_hour = 6'h07; al_date = 6'h08; al_month = 5'h09;
        time_eq(); tm_month = 5'h10; rpt_bits = 5'b00000;
        time_upd = 1; step(); time_upd = 0;
        chk("R1 month differs", alarm_flag, 0);
        time_eq(); time_upd = 1; step(); time_upd = 0;
        chk("R1 year match", alarm_flag, 1);
        clear_flag();

        // R1 day repeat: date ignored
        time_eq(); tm_date = 6'h21; tm_month = 5'h01; rpt_bits = 5'b11000;
        time_upd = 1; step(); time_upd = 0;
        chk("R1 day ignores date", alarm_flag, 1);
        clear_flag();

        // R2 undefined code
        rpt_bits = 5'b10101; tm_sec = 7'h59; tm_hour = 6'h00;
        time_upd = 1; step(); time_upd = 0;
        chk("R2 fallback", alarm_flag, 1);
        clear_flag();

        // R3 equal fields without update strobe
        rpt_bits = 5'b11111; time_upd = 0; step();
        chk("R3 no strobe", alarm_flag, 0);

        // R4 pointer parked on flags address
        reg_ptr = 8'h0F; time_upd = 1; step(); time_upd = 0;
        chk("R4 held", alarm_flag, 0);
        flags_rd = 1; step(); flags_rd = 0;
        chk("R4 read while held", alarm_flag, 0);
        reg_ptr = 8'h10; step();
        chk("R4 released", alarm_flag, 1);

        // R5 read and match collide
        flags_rd = 1; time_upd = 1; step();
        chk("R5 collision keeps flag", alarm_flag, 1);
        time_upd = 0; step(); flags_rd = 0;
        chk("R5 read clears", alarm_flag, 0);

        // R8 static level
        alm_en = 0; out_level = 0; step();
        chk("R8 low", mfp_pull_low, 1);
        out_level = 1; step();
        chk("R8 high", mfp_pull_low, 0);

        // R7 wave overrides alarm
        alm_en = 1; time_upd = 1; step(); time_upd = 0;
        sqw_en = 1; rate_sel = 0; step();
        chk("R7 rate zero", mfp_pull_low, 0);
        for (int r = 1; r < 16; r++) begin
            rate_sel = 4'(r);
            for (int k = 0; k < 6; k++) begin
                osc_half_tick = 1; step();
            end
        end
        osc_half_tick = 0; sqw_en = 0; clear_flag();

        // R9 stop freezes divider and releases f32
        osc_stop = 1; osc_half_tick = 1;
        for (int k = 0; k < 5; k++) step();
        chk("R9 stopped", f32_pull_low, 0);
        osc_stop = 0; osc_half_tick = 0;

        // random phase
        for (int n = 0; n < 4000; n++) begin
            al_sec = 7'($urandom_range(0, 3)); al_min = 7'($urandom_range(0, 1));
            al_hour = 6'($urandom_range(0, 1)); al_date = 6'($urandom_range(0, 1));
            al_month = 5'($urandom_range(0, 1));
            time_eq();
            if ($urandom_range(0, 2) == 0) tm_sec = 7'($urandom_range(0, 3));
            if ($urandom_range(0, 3) == 0) tm_min = 7'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) tm_hour = 6'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) tm_date = 6'($urandom_range(0, 1));
            if ($urandom_range(0, 3) == 0) tm_month = 5'($urandom_range(0, 1));
            case ($urandom_range(0, 6))
                0: rpt_bits = 5'b11111;
                1: rpt_bits = 5'b11110;
                2: rpt_bits = 5'b11100;
                3: rpt_bits = 5'b11000;
                4: rpt_bits = 5'b10000;
                5: rpt_bits = 5'b00000;
                default: rpt_bits = 5'($urandom);
            endcase
            time_upd = ($urandom_range(0, 2) == 0);
            flags_rd = ($urandom_range(0, 5) == 0);
            reg_ptr = ($urandom_range(0, 3) == 0) ? 8'h0F : 8'($urandom_range(0, 19));
            osc_half_tick = $urandom_range(0, 1) != 0;
            osc_stop = ($urandom_range(0, 15) == 0);
            f32_en = ($urandom_range(0, 7) != 0);
            alm_en = $urandom_range(0, 1) != 0;
            sqw_en = ($urandom_range(0, 3) == 0);
            rate_sel = 4'($urandom);
            out_level = $urandom_range(0, 1) != 0;
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule